// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block produces the interrupt conditions of a synchronous serial port that owns a receive FIFO and a transmit FIFO. The FIFOs and the shift engine live elsewhere. They report to this block through occupancy counts, a strobe for each frame that lands in the receive FIFO, and a strobe for each read from it. The block watches those signals and keeps four raw conditions: receive overrun, receive timeout, receive FIFO half full, and transmit FIFO half empty.

A small word-addressed register port exposes the conditions to software. Software can write a mask, read the raw and masked status, and write a clear word that drops the two sticky conditions. One interrupt line carries the OR of the masked conditions.

The receive timeout measures 32 serial bit periods. One bit period is `prescale * (rate + 1)` system clock cycles, and the same period applies whichever side drives the serial clock.

All pins are plain control and status signals. No interface here transfers data, so no port uses valid/ready or back-pressure. A register write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `serport_irq`

## Requirements
- R1: Status and mask words use fixed bit positions: bit 0 overrun, bit 1 timeout, bit 2 RX half full, bit 3 TX half empty. Bits 31:4 of every readable word read 0. Word addresses are 0 mask (read/write), 1 raw status, 2 masked status and 3 clear (write only, reads 0). Any other address reads 0.
- R2: Raw status shows every active condition regardless of the mask. Masked status equals raw status AND mask, bit for bit.
- R3: The overrun bit sets on the clock edge where `rx_frame_done` is high while `rx_count` equals DEPTH. A frame that completes with fewer entries stored leaves the bit unchanged.
- R4: The timeout bit sets on the edge that completes 32 bit periods of `rx_count` being nonzero with no restart, where one bit period is `prescale*(rate+1)` cycles.
- R5: An `rx_pop` or `rx_frame_done` pulse restarts the timeout measurement from zero. While `rx_count` is 0 the measurement is held at zero, so the timeout bit never sets.
- R6: The RX half-full bit is 1 exactly while `rx_count >= DEPTH/2`.
- R7: The TX half-empty bit is 1 exactly while `DEPTH - tx_count >= DEPTH/2`.
- R8: After reset the mask is 0, raw bits 0 to 2 are 0, the `irq` output is 0, and raw bit 3 reads 1 while `tx_count` is 0.
- R9: A mask write stores only bits 3:0. Ones written to bits 31:4 have no effect on the value read back.
- R10: Overrun and timeout are sticky. Writing 1 to bit 0 or bit 1 of the clear word clears them. If a set and a clear arrive on the same edge, the set wins.
- R11: `irq` is a register that holds the OR of the masked status from the previous cycle, so it lags by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Entries held in the receive FIFO |
| tx_count | input | CNT_W | Entries held in the transmit FIFO |
| rx_frame_done | input | 1 | One-cycle strobe: a frame completed into the receive FIFO |
| rx_pop | input | 1 | One-cycle strobe: software read the receive FIFO |
| prescale | input | PRE_W | Clock prescaler divisor (0 treated as 1) |
| rate | input | RATE_W | Serial clock rate field; divides by rate+1 |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench counts cycles across the timeout window. It expects the timeout bit to be clear one cycle before 32 bit periods have passed and set on the exact edge where they complete. An off-by-one in the nested dividers would move that edge, and a missed restart would let two partial windows add up to a false timeout. Overrun is driven both at one entry below full and at full. It is also driven on the same edge as a clear write, which exposes an inverted set/clear priority. Level thresholds are walked through values on both sides of the half mark, which catches a `>` written where `>=` belongs. The `irq` line is sampled in the cycle a mask is written, which catches a combinational or two-stage output.

// File: rtl/serport_irq_pkg.sv
package serport_irq_pkg;
  localparam int unsigned NUM_SRC     = 4;
  localparam int unsigned SRC_OVR     = 0;
  localparam int unsigned SRC_TMO     = 1;
  localparam int unsigned SRC_RXH     = 2;
  localparam int unsigned SRC_TXH     = 3;
  localparam int unsigned NUM_STICKY  = 2;
  localparam int unsigned BIT_PERIODS = 32;

  typedef enum logic [1:0] {
    REG_MASK   = 2'd0,
    REG_RAW    = 2'd1,
    REG_MASKED = 2'd2,
    REG_CLEAR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/serport_irq_timer.sv
module serport_irq_timer
  import serport_irq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_frame_done,
  input  logic              rx_pop,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  output logic              timeout_hit
);
  localparam int BITS_W = $clog2(BIT_PERIODS);

  logic [PRE_W-1:0]  pre_cnt;
  logic [RATE_W-1:0] rate_cnt;
  logic [BITS_W-1:0] bit_cnt;
  logic [PRE_W:0]    pre_next;
  logic              pre_last, rate_last, bit_tick, restart;

  assign restart   = (rx_count == '0) | rx_pop | rx_frame_done;
  assign pre_next  = {1'b0, pre_cnt} + 1'b1;
  assign pre_last  = pre_next >= {1'b0, prescale};
  assign rate_last = rate_cnt == rate;
  assign bit_tick  = pre_last & rate_last;
  assign timeout_hit = !restart & bit_tick &
                       (bit_cnt == BITS_W'(BIT_PERIODS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      bit_cnt  <= '0;
    end else if (restart) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      bit_cnt  <= '0;
    end else if (pre_last) begin
      pre_cnt <= '0;
      if (rate_last) begin
        rate_cnt <= '0;
        bit_cnt  <= bit_cnt + 1'b1;
      end else begin
        rate_cnt <= rate_cnt + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R5
  restart_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !timeout_hit);

  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> (bit_cnt == '0 && rate_cnt == '0 && pre_cnt == '0));
endmodule

// File: rtl/serport_irq_sources.sv
module serport_irq_sources
  import serport_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic               rx_frame_done,
  input  logic               timeout_hit,
  input  logic [NUM_STICKY-1:0] sticky_clr,
  output logic [NUM_SRC-1:0] raw
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

  logic [NUM_STICKY-1:0] sticky_set, sticky_q;
  logic [CNT_W-1:0]      tx_free;

  assign sticky_set[SRC_OVR] = rx_frame_done & (rx_count == FULL_LVL);
  assign sticky_set[SRC_TMO] = timeout_hit;

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[i] <= 1'b0;
      else        sticky_q[i] <= sticky_set[i] | (sticky_q[i] & ~sticky_clr[i]);
    end
  end

  assign tx_free = FULL_LVL - tx_count;

  always_comb begin
    raw          = '0;
    raw[SRC_OVR] = sticky_q[SRC_OVR];
    raw[SRC_TMO] = sticky_q[SRC_TMO];
    raw[SRC_RXH] = rx_count >= HALF_LVL;
    raw[SRC_TXH] = tx_free >= HALF_LVL;
  end

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_done && rx_count == FULL_LVL) |=> raw[SRC_OVR]);

  // R10
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr[SRC_OVR] && !sticky_set[SRC_OVR]) |=> !raw[SRC_OVR]);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[SRC_TMO] && !sticky_clr[SRC_TMO]) |=> raw[SRC_TMO]);
endmodule

// File: rtl/serport_irq_regs.sv
module serport_irq_regs
  import serport_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [31:0]           reg_wdata,
  input  logic [NUM_SRC-1:0]    raw,
  output logic [NUM_STICKY-1:0] sticky_clr,
  output logic [31:0]           reg_rdata,
  output logic                  irq
);
  logic [NUM_SRC-1:0] mask_q, masked;
  logic               in_range;
  reg_sel_e           sel;
  logic               wr_mask, wr_clear;

  assign in_range = (reg_addr >> 2) == '0;
  assign sel      = reg_sel_e'(reg_addr[1:0]);
  assign wr_mask  = reg_wr & in_range & (sel == REG_MASK);
  assign wr_clear = reg_wr & in_range & (sel == REG_CLEAR);
  assign sticky_clr = wr_clear ? reg_wdata[NUM_STICKY-1:0] : '0;
  assign masked   = raw & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
      irq <= |masked;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_range) begin
      case (sel)
        REG_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
        REG_RAW:    reg_rdata[NUM_SRC-1:0] = raw;
        REG_MASKED: reg_rdata[NUM_SRC-1:0] = masked;
        default:    reg_rdata = '0;
      endcase
    end
  end

  // R9
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0])));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(raw & mask_q)));

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:NUM_SRC] == '0);
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_irq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_frame_done,
  input  logic              rx_pop,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                  timeout_hit;
  logic [NUM_SRC-1:0]    raw;
  logic [NUM_STICKY-1:0] sticky_clr;

  serport_irq_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count),
    .rx_frame_done(rx_frame_done), .rx_pop(rx_pop),
    .prescale(prescale), .rate(rate), .timeout_hit(timeout_hit)
  );

  serport_irq_sources #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .rx_frame_done(rx_frame_done), .timeout_hit(timeout_hit),
    .sticky_clr(sticky_clr), .raw(raw)
  );

  serport_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .raw(raw), .sticky_clr(sticky_clr),
    .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: tb/sim_serport_irq.sv
module sim_serport_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  // {rx_count, tx_count, expected {tx_half_empty, rx_half_full}}
  localparam logic [9:0] VEC [0:7] = '{
    {4'd0, 4'd0, 2'b10}, {4'd3, 4'd4, 2'b10},
    {4'd4, 4'd5, 2'b01}, {4'd8, 4'd8, 2'b01},
    {4'd5, 4'd3, 2'b11}, {4'd2, 4'd7, 2'b00},
    {4'd7, 4'd0, 2'b11}, {4'd1, 4'd6, 2'b00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic rx_frame_done = 1'b0, rx_pop = 1'b0, reg_wr = 1'b0, irq;
  logic [7:0] prescale = 8'd2, rate = 8'd1;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rd;
  int n_run = 0, n_fail = 0;

  serport_irq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_pop();
    rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
  endtask

  task automatic pulse_frame();
    rx_frame_done = 1'b1; tick(1); rx_frame_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R8 reset state
    rd_reg(4'd0, rd); chk("R8 mask", rd, 32'h0);
    rd_reg(4'd1, rd); chk("R8 raw", rd, 32'h8);
    chk("R8 irq", {31'b0, irq}, 32'h0);
    rd_reg(4'd3, rd); chk("R1 clear reads 0", rd, 32'h0);
    rd_reg(4'd9, rd); chk("R1 unmapped", rd, 32'h0);

    // R9 reserved mask bits, R11 irq latency
    wr_reg(4'd0, 32'hFFFF_FFFF);
    chk("R11 irq same cycle", {31'b0, irq}, 32'h0);
    tick(1);
    chk("R11 irq next cycle", {31'b0, irq}, 32'h1);
    rd_reg(4'd0, rd); chk("R9 mask readback", rd, 32'hF);
    wr_reg(4'd0, 32'h0000_0004);
    rd_reg(4'd2, rd); chk("R2 masked", rd, 32'h0);
    tick(1);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);

    // R6 R7 level thresholds
    for (int i = 0; i < 8; i++) begin
      rx_count = VEC[i][9:6]; tx_count = VEC[i][5:2];
      tick(1);
      rd_reg(4'd1, rd);
      chk("R6/R7 levels", {30'b0, rd[3:2]}, {30'b0, VEC[i][1:0]});
      rd_reg(4'd2, rd);
      chk("R2 masked levels", rd, {29'b0, VEC[i][0], 2'b0});
    end

    // R3 overrun
    rx_count = '0; tx_count = '0; tick(2);
    wr_reg(4'd3, 32'h3);
    rx_count = CNT_W'(DEPTH - 1);
    pulse_frame();
    rd_reg(4'd1, rd); chk("R3 below full", {31'b0, rd[0]}, 32'h0);
    rx_count = CNT_W'(DEPTH);
    pulse_frame();
    rd_reg(4'd1, rd); chk("R3 full", {31'b0, rd[0]}, 32'h1);
    rd_reg(4'd2, rd); chk("R2 unmasked overrun hidden", {31'b0, rd[0]}, 32'h0);
    wr_reg(4'd3, 32'h1);
    rd_reg(4'd1, rd); chk("R10 clear", {31'b0, rd[0]}, 32'h0);
    // R10 set beats clear
    reg_addr = 4'd3; reg_wdata = 32'h1; reg_wr = 1'b1; rx_frame_done = 1'b1;
    tick(1);
    reg_wr = 1'b0; rx_frame_done = 1'b0;
    rd_reg(4'd1, rd); chk("R10 set wins", {31'b0, rd[0]}, 32'h1);
    wr_reg(4'd3, 32'h1);

    // R4 timeout: period 2*(1+1)=4 cycles, 128 cycles total
    rx_count = '0; tick(2);
    wr_reg(4'd3, 32'h3);
    rx_count = 4'd1;
    tick(127);
    rd_reg(4'd1, rd); chk("R4 before window", {31'b0, rd[1]}, 32'h0);
    tick(1);
    rd_reg(4'd1, rd); chk("R4 at window", {31'b0, rd[1]}, 32'h1);
    tick(20);
    rd_reg(4'd1, rd); chk("R10 timeout sticky", {31'b0, rd[1]}, 32'h1);

    // R5 restart on pop
    wr_reg(4'd3, 32'h2);
    pulse_pop();
    tick(100);
    pulse_pop();
    tick(127);
    rd_reg(4'd1, rd); chk("R5 pop restarts", {31'b0, rd[1]}, 32'h0);
    tick(1);
    rd_reg(4'd1, rd); chk("R5 after restart window", {31'b0, rd[1]}, 32'h1);

    // R5 held while empty
    rx_count = '0; tick(1);
    wr_reg(4'd3, 32'h2);
    tick(300);
    rd_reg(4'd1, rd); chk("R5 empty holds", {31'b0, rd[1]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule